// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Register Interface

This block is the processor-facing front end of a combined memory, I/O and timer peripheral. It sits on a multiplexed 8-bit address/data bus. A falling address strobe latches the address, the chip-select level and the memory/I-O select into the block. The RD or WR pulse that follows is then steered either to a 256-byte static RAM or to a small bank of I/O registers.

The block holds the write-only command byte. It hands the command fields and one-cycle write strobes to the port and timer logic around it, and it takes back their status flags. From those flags and a latched timer flag it assembles a read-only status byte. The tri-state bus is split into an input path, an output path and an output enable. All bus inputs are sampled by the block clock.

Top module: `pbi_bus_iface`

## Requirements
- R1: On a sampled falling edge of `ale`, the block captures `ad_in`, the chip-select level and `io_m`. The following RD or WR cycle uses only these captured values, even if those pins change during the cycle.
- R2: With a captured `io_m` of 0, a write stores the byte at the captured address in a 256x8 RAM and a read returns it. A later write to the same address replaces the byte.
- R3: With a captured `io_m` of 1, only address bits 2:0 select a register. The codes are 000 command/status, 001 port A, 010 port B, 011 port C (6 bits, read with bits 7:6 as 0), 100 count low byte, and 101 count high byte with mode bits. A write gives exactly one one-cycle strobe for the selected register, with the byte on `wstb_data`, in the cycle after the clock edge that samples `wr_n` high again.
- R4: A write to code 000 loads the command byte: bit 0 port A output, bit 1 port B output, bits 3:2 port C mode, bit 4 port A interrupt enable, bit 5 port B interrupt enable, bits 7:6 timer command. A read of code 000 never returns this byte.
- R5: A read of code 000 returns status: bit 0 A interrupt, bit 1 A full, bit 2 A interrupt enable, bit 3 B interrupt, bit 4 B full, bit 5 B interrupt enable, bit 6 timer flag, and bit 7 always 0.
- R6: A `tmr_tc` pulse sets the timer flag. The rising edge of `rd_n` that ends a status read clears it, so the byte just read still shows it set. Reads of other addresses leave it unchanged. When a `tmr_tc` pulse and a clearing RD edge come in the same cycle, the flag stays set.
- R7: The chip-select polarity is a parameter (0: active low, 1: active high). When the captured select is inactive, the block does not enable the bus, writes nothing to the RAM or the command byte, and gives no strobe.
- R8: With `rst` high (synchronous), the command byte becomes 0x00, so all three ports are inputs and port C is in mode 00. The timer flag clears.
- R9: `ad_oe` is high only while `rd_n` is low and the captured select is active. While `ad_oe` is low, `ad_out` is 0x00. I/O codes 110 and 111 read as 0x00, and writes to them give no strobe and do not change the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; its falling edge latches the selection |
| io_m | input | 1 | 0 selects the RAM, 1 selects I/O registers |
| ce_pin | input | 1 | Chip select, polarity set by CE_ACTIVE_HIGH |
| rd_n | input | 1 | Read pulse, active low |
| wr_n | input | 1 | Write pulse, active low |
| ad_in | input | 8 | Multiplexed bus, incoming side |
| ad_out | output | 8 | Multiplexed bus, outgoing side |
| ad_oe | output | 1 | Enables the outgoing bus driver |
| pa_rdata | input | 8 | Port A read value |
| pb_rdata | input | 8 | Port B read value |
| pc_rdata | input | 6 | Port C read value |
| cnt_lo_rdata | input | 8 | Count register low byte |
| cnt_hi_rdata | input | 8 | Count register high byte and mode |
| a_irq | input | 1 | Port A interrupt request |
| a_full | input | 1 | Port A buffer full |
| b_irq | input | 1 | Port B interrupt request |
| b_full | input | 1 | Port B buffer full |
| tmr_tc | input | 1 | Terminal-count pulse from the timer |
| pa_is_out | output | 1 | Port A direction, 1 = output |
| pb_is_out | output | 1 | Port B direction, 1 = output |
| pc_mode | output | 2 | Port C mode field |
| irq_en_a | output | 1 | Port A interrupt enable |
| irq_en_b | output | 1 | Port B interrupt enable |
| tmr_cmd | output | 2 | Timer command field |
| cmd_wstb | output | 1 | Command byte written |
| pa_wstb | output | 1 | Port A register write strobe |
| pb_wstb | output | 1 | Port B register write strobe |
| pc_wstb | output | 1 | Port C register write strobe |
| cnt_lo_wstb | output | 1 | Count low byte write strobe |
| cnt_hi_wstb | output | 1 | Count high byte write strobe |
| wstb_data | output | 8 | Byte carried with the write strobes |

## Verification
The embedded properties take it as given that every bus input is synchronous to `clk`. They also assume that `ale` falls only while `rd_n` and `wr_n` are both high, that the address stays on `ad_in` for the cycle in which the fall is sampled, that `rd_n` and `wr_n` are never low together, and that `tmr_tc` is a single-cycle pulse. The stimulus tasks respect all of this. They drive every pin on the falling clock edge, run each access as a fixed sequence (address phase, ALE drop, one low cycle of RD or WR, one recovery cycle), and raise the terminal-count input for one cycle only. The one deliberate break from this sequence is a test that changes the select pins and the bus inside a read, to show that only the latched values count.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

    localparam int BUS_W       = 8;
    localparam int IO_SEL_W    = 3;
    localparam int PC_W        = 6;
    localparam int NUM_IO_REGS = 6;

    typedef enum logic [IO_SEL_W-1:0] {
        SEL_CS   = 3'd0,
        SEL_PA   = 3'd1,
        SEL_PB   = 3'd2,
        SEL_PC   = 3'd3,
        SEL_CLO  = 3'd4,
        SEL_CHI  = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } io_sel_e;

    // Command byte, most significant field first.
    typedef struct packed {
        logic [1:0] tmr_cmd;
        logic       ie_b;
        logic       ie_a;
        logic [1:0] pc_mode;
        logic       pb_out;
        logic       pa_out;
    } cmd_t;

    // Status byte, most significant bit first.
    typedef struct packed {
        logic zero;
        logic tmr_flag;
        logic ie_b;
        logic full_b;
        logic irq_b;
        logic ie_a;
        logic full_a;
        logic irq_a;
    } stat_t;

    // Selection captured at the address strobe.
    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic             ce_act;
        logic             is_io;
    } bus_sel_t;

    function automatic io_sel_e io_decode(input logic [BUS_W-1:0] a);
        return io_sel_e'(a[IO_SEL_W-1:0]);
    endfunction

    function automatic logic io_present(input io_sel_e s);
        return (s != SEL_RSV6) && (s != SEL_RSV7);
    endfunction

    function automatic stat_t build_status(input cmd_t c, input logic ai, input logic af,
                                           input logic bi, input logic bf, input logic tf);
        stat_t s;
        s.zero     = 1'b0;
        s.tmr_flag = tf;
        s.ie_b     = c.ie_b;
        s.full_b   = bf;
        s.irq_b    = bi;
        s.ie_a     = c.ie_a;
        s.full_a   = af;
        s.irq_a    = ai;
        return s;
    endfunction

endpackage

// File: rtl/pbi_addr_latch.sv
module pbi_addr_latch
    import pbi_pkg::*;
#(
    parameter bit CE_ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ale,
    input  logic             io_m,
    input  logic             ce_pin,
    input  logic [BUS_W-1:0] ad_in,
    output bus_sel_t         sel
);

    logic ale_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            sel   <= '0;
        end else begin
            ale_q <= ale;
            if (ale_q && !ale) begin
                sel.addr   <= ad_in;
                sel.ce_act <= (ce_pin == CE_ACTIVE_HIGH);
                sel.is_io  <= io_m;
            end
        end
    end

    // R1: the selection only moves on a sampled falling address strobe
    p_sel_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(ale_q && !ale) |=> $stable(sel));

endmodule

// File: rtl/pbi_ram.sv
module pbi_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pbi_csr.sv
module pbi_csr
    import pbi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             stat_clr,
    input  logic             tmr_tc,
    input  logic             a_irq,
    input  logic             a_full,
    input  logic             b_irq,
    input  logic             b_full,
    output cmd_t             cmd,
    output stat_t            stat
);

    logic tmr_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= '0;
            tmr_flag <= 1'b0;
        end else begin
            if (cmd_we) begin
                cmd <= cmd_t'(wdata);
            end
            if (tmr_tc) begin
                tmr_flag <= 1'b1;
            end else if (stat_clr) begin
                tmr_flag <= 1'b0;
            end
        end
    end

    assign stat = build_status(cmd, a_irq, a_full, b_irq, b_full, tmr_flag);

    // R6: flag rises only after a terminal-count pulse
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_flag) |-> $past(tmr_tc));

    // R6: flag falls only after the end of a status read
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tmr_flag) |-> $past(stat_clr));

    // R4: the command byte changes only through a command write
    p_cmd_write_only_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd) |-> $past(cmd_we));

    // R8: leaving reset, all ports are inputs and port C is in mode 00
    p_reset_inputs_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd == '0));

endmodule

// File: rtl/pbi_bus_iface.sv
module pbi_bus_iface
    import pbi_pkg::*;
#(
    parameter bit CE_ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ale,
    input  logic             io_m,
    input  logic             ce_pin,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    input  logic [BUS_W-1:0] pa_rdata,
    input  logic [BUS_W-1:0] pb_rdata,
    input  logic [PC_W-1:0]  pc_rdata,
    input  logic [BUS_W-1:0] cnt_lo_rdata,
    input  logic [BUS_W-1:0] cnt_hi_rdata,
    input  logic             a_irq,
    input  logic             a_full,
    input  logic             b_irq,
    input  logic             b_full,
    input  logic             tmr_tc,
    output logic             pa_is_out,
    output logic             pb_is_out,
    output logic [1:0]       pc_mode,
    output logic             irq_en_a,
    output logic             irq_en_b,
    output logic [1:0]       tmr_cmd,
    output logic             cmd_wstb,
    output logic             pa_wstb,
    output logic             pb_wstb,
    output logic             pc_wstb,
    output logic             cnt_lo_wstb,
    output logic             cnt_hi_wstb,
    output logic [BUS_W-1:0] wstb_data
);

    localparam int PC_PAD = BUS_W - PC_W;

    bus_sel_t                 sel;
    io_sel_e                  io_sel;
    cmd_t                     cmd;
    stat_t                    stat;
    logic                     rd_low_q;
    logic                     wr_low_q;
    logic [BUS_W-1:0]         wdat_q;
    logic [BUS_W-1:0]         wstb_data_q;
    logic [NUM_IO_REGS-1:0]   io_wr_q;
    logic [BUS_W-1:0]         ram_rdata;
    logic [BUS_W-1:0]         rd_mux;
    logic                     wr_commit;
    logic                     rd_done;
    logic                     ram_we;
    logic                     io_we;
    logic                     cmd_we;
    logic                     stat_clr;

    pbi_addr_latch #(
        .CE_ACTIVE_HIGH (CE_ACTIVE_HIGH)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .ale    (ale),
        .io_m   (io_m),
        .ce_pin (ce_pin),
        .ad_in  (ad_in),
        .sel    (sel)
    );

    assign io_sel    = io_decode(sel.addr);
    assign wr_commit = wr_low_q && wr_n && sel.ce_act;
    assign rd_done   = rd_low_q && rd_n && sel.ce_act;
    assign ram_we    = wr_commit && !sel.is_io;
    assign io_we     = wr_commit && sel.is_io && io_present(io_sel);
    assign cmd_we    = io_we && (io_sel == SEL_CS);
    assign stat_clr  = rd_done && sel.is_io && (io_sel == SEL_CS);

    // Bus phase tracking and write strobes.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_low_q    <= 1'b0;
            wr_low_q    <= 1'b0;
            wdat_q      <= '0;
            wstb_data_q <= '0;
            io_wr_q     <= '0;
        end else begin
            rd_low_q <= !rd_n;
            wr_low_q <= !wr_n;
            if (!wr_n) begin
                wdat_q <= ad_in;
            end
            for (int g = 0; g < NUM_IO_REGS; g++) begin
                io_wr_q[g] <= io_we && (io_sel == io_sel_e'(g));
            end
            if (io_we) begin
                wstb_data_q <= wdat_q;
            end
        end
    end

    pbi_ram #(
        .AW (BUS_W),
        .DW (BUS_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (sel.addr),
        .wdata (wdat_q),
        .rdata (ram_rdata)
    );

    pbi_csr u_csr (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .wdata    (wdat_q),
        .stat_clr (stat_clr),
        .tmr_tc   (tmr_tc),
        .a_irq    (a_irq),
        .a_full   (a_full),
        .b_irq    (b_irq),
        .b_full   (b_full),
        .cmd      (cmd),
        .stat     (stat)
    );

    // Read steering.
    always_comb begin
        rd_mux = '0;
        if (!sel.is_io) begin
            rd_mux = ram_rdata;
        end else begin
            case (io_sel)
                SEL_CS:  rd_mux = stat;
                SEL_PA:  rd_mux = pa_rdata;
                SEL_PB:  rd_mux = pb_rdata;
                SEL_PC:  rd_mux = {{PC_PAD{1'b0}}, pc_rdata};
                SEL_CLO: rd_mux = cnt_lo_rdata;
                SEL_CHI: rd_mux = cnt_hi_rdata;
                default: rd_mux = '0;
            endcase
        end
    end

    assign ad_oe  = !rd_n && sel.ce_act;
    assign ad_out = ad_oe ? rd_mux : '0;

    assign pa_is_out   = cmd.pa_out;
    assign pb_is_out   = cmd.pb_out;
    assign pc_mode     = cmd.pc_mode;
    assign irq_en_a    = cmd.ie_a;
    assign irq_en_b    = cmd.ie_b;
    assign tmr_cmd     = cmd.tmr_cmd;
    assign cmd_wstb    = io_wr_q[int'(SEL_CS)];
    assign pa_wstb     = io_wr_q[int'(SEL_PA)];
    assign pb_wstb     = io_wr_q[int'(SEL_PB)];
    assign pc_wstb     = io_wr_q[int'(SEL_PC)];
    assign cnt_lo_wstb = io_wr_q[int'(SEL_CLO)];
    assign cnt_hi_wstb = io_wr_q[int'(SEL_CHI)];
    assign wstb_data   = wstb_data_q;

    // R3: never more than one register strobe at a time
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(io_wr_q));

    // R3: a strobe follows the clock edge that saw WR return high
    p_strobe_after_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (|io_wr_q) |-> ($past(wr_n) && $past(wr_low_q)));

    // R7: an inactive selection never produces a strobe
    p_no_strobe_inactive_r7: assert property (@(posedge clk) disable iff (rst)
        (|io_wr_q) |-> $past(sel.ce_act));

endmodule

// File: tb/tb_pbi_bus_iface.sv
module tb_pbi_bus_iface;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       io_m = 1'b0;
    logic       ce_pin = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] pa_rdata = 8'h96;
    logic [7:0] pb_rdata = 8'hC4;
    logic [5:0] pc_rdata = 6'h2B;
    logic [7:0] cnt_lo_rdata = 8'h5E;
    logic [7:0] cnt_hi_rdata = 8'h81;
    logic       a_irq = 1'b1;
    logic       a_full = 1'b0;
    logic       b_irq = 1'b0;
    logic       b_full = 1'b1;
    logic       tmr_tc = 1'b0;
    logic       pa_is_out, pb_is_out, irq_en_a, irq_en_b;
    logic [1:0] pc_mode, tmr_cmd;
    logic       cmd_wstb, pa_wstb, pb_wstb, pc_wstb, cnt_lo_wstb, cnt_hi_wstb;
    logic [7:0] wstb_data;

    logic [7:0] hi_ad_out;
    logic       hi_ad_oe;
    logic       hi_pa_is_out, hi_pb_is_out, hi_irq_en_a, hi_irq_en_b;
    logic [1:0] hi_pc_mode, hi_tmr_cmd;
    logic       hi_s0, hi_s1, hi_s2, hi_s3, hi_s4, hi_s5;
    logic [7:0] hi_wstb_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pbi_bus_iface dut (
        .clk(clk), .rst(rst), .ale(ale), .io_m(io_m), .ce_pin(ce_pin),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .pa_rdata(pa_rdata), .pb_rdata(pb_rdata), .pc_rdata(pc_rdata),
        .cnt_lo_rdata(cnt_lo_rdata), .cnt_hi_rdata(cnt_hi_rdata),
        .a_irq(a_irq), .a_full(a_full), .b_irq(b_irq), .b_full(b_full), .tmr_tc(tmr_tc),
        .pa_is_out(pa_is_out), .pb_is_out(pb_is_out), .pc_mode(pc_mode),
        .irq_en_a(irq_en_a), .irq_en_b(irq_en_b), .tmr_cmd(tmr_cmd),
        .cmd_wstb(cmd_wstb), .pa_wstb(pa_wstb), .pb_wstb(pb_wstb), .pc_wstb(pc_wstb),
        .cnt_lo_wstb(cnt_lo_wstb), .cnt_hi_wstb(cnt_hi_wstb), .wstb_data(wstb_data)
    );

    // Second copy with the opposite select polarity on the same pins.
    pbi_bus_iface #(.CE_ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .ale(ale), .io_m(io_m), .ce_pin(ce_pin),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(hi_ad_out), .ad_oe(hi_ad_oe),
        .pa_rdata(pa_rdata), .pb_rdata(pb_rdata), .pc_rdata(pc_rdata),
        .cnt_lo_rdata(cnt_lo_rdata), .cnt_hi_rdata(cnt_hi_rdata),
        .a_irq(a_irq), .a_full(a_full), .b_irq(b_irq), .b_full(b_full), .tmr_tc(tmr_tc),
        .pa_is_out(hi_pa_is_out), .pb_is_out(hi_pb_is_out), .pc_mode(hi_pc_mode),
        .irq_en_a(hi_irq_en_a), .irq_en_b(hi_irq_en_b), .tmr_cmd(hi_tmr_cmd),
        .cmd_wstb(hi_s0), .pa_wstb(hi_s1), .pb_wstb(hi_s2), .pc_wstb(hi_s3),
        .cnt_lo_wstb(hi_s4), .cnt_hi_wstb(hi_s5), .wstb_data(hi_wstb_data)
    );

    // {write, address, data, expected read}
    localparam logic [24:0] VEC [10] = '{
        {1'b1, 8'h00, 8'h11, 8'h00},
        {1'b1, 8'hFF, 8'hEE, 8'h00},
        {1'b1, 8'h80, 8'hC3, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'h11},
        {1'b0, 8'hFF, 8'h00, 8'hEE},
        {1'b1, 8'h00, 8'h3C, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'h3C},
        {1'b0, 8'h80, 8'h00, 8'hC3},
        {1'b1, 8'h7F, 8'h00, 8'h00},
        {1'b0, 8'h7F, 8'h00, 8'h00}
    };

    function automatic logic [7:0] exp_stat(input logic [7:0] c, input logic tf);
        return {1'b0, tf, c[5], b_full, b_irq, c[4], a_full, a_irq};
    endfunction

    function automatic logic [7:0] cmd_now();
        return {tmr_cmd, irq_en_b, irq_en_a, pc_mode, pb_is_out, pa_is_out};
    endfunction

    function automatic logic [5:0] strobes();
        return {cmd_wstb, pa_wstb, pb_wstb, pc_wstb, cnt_lo_wstb, cnt_hi_wstb};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic iom, input logic [7:0] a, input logic ce_on);
        @(negedge clk);
        ale = 1'b1; ad_in = a; io_m = iom; ce_pin = ce_on ? 1'b0 : 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic iom, input logic [7:0] a, input logic ce_on,
                            input logic [7:0] d);
        addr_phase(iom, a, ce_on);
        ad_in = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic iom, input logic [7:0] a, input logic ce_on,
                           output logic [7:0] d, output logic oe);
        addr_phase(iom, a, ce_on);
        rd_n = 1'b0;
        #1;
        d = ad_out; oe = ad_oe;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_tc();
        @(negedge clk);
        tmr_tc = 1'b1;
        @(negedge clk);
        tmr_tc = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic       oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        chk("R8 cmd after reset", cmd_now(), 8'h00);
        chk("R9 oe idle after reset", ad_oe, 1'b0);
        chk("R3 no strobe after reset", strobes(), 6'b0);

        // R2: vector table
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][24]) begin
                do_write(1'b0, VEC[i][23:16], 1'b1, VEC[i][15:8]);
            end else begin
                do_read(1'b0, VEC[i][23:16], 1'b1, d, oe);
                chk("R2 table read", d, VEC[i][7:0]);
                chk("R9 oe on RAM read", oe, 1'b1);
            end
        end

        // R2: full sweep
        for (int a = 0; a < 256; a++) do_write(1'b0, 8'(a), 1'b1, 8'(a) ^ 8'h5A);
        for (int a = 0; a < 256; a++) begin
            do_read(1'b0, 8'(a), 1'b1, d, oe);
            chk("R2 sweep", d, 8'(a) ^ 8'h5A);
        end

        // R1: pins changed inside the read do not matter
        do_write(1'b0, 8'h10, 1'b1, 8'hAA);
        addr_phase(1'b0, 8'h10, 1'b1);
        io_m = 1'b1; ce_pin = 1'b1; ad_in = 8'h20; rd_n = 1'b0;
        #1;
        chk("R1 latched oe", ad_oe, 1'b1);
        chk("R1 latched data", ad_out, 8'hAA);
        @(negedge clk); rd_n = 1'b1; @(negedge clk);

        // R7: inactive select, both polarities
        do_write(1'b0, 8'h10, 1'b0, 8'h55);
        addr_phase(1'b0, 8'h10, 1'b1);
        rd_n = 1'b0; #1;
        chk("R7 low-active read", ad_out, 8'hAA);
        chk("R7 high-active copy idle", hi_ad_oe, 1'b0);
        @(negedge clk); rd_n = 1'b1; @(negedge clk);
        addr_phase(1'b0, 8'h10, 1'b0);
        rd_n = 1'b0; #1;
        chk("R7 low-active deselected oe", ad_oe, 1'b0);
        chk("R7 deselected bus", ad_out, 8'h00);
        chk("R7 high-active oe", hi_ad_oe, 1'b1);
        chk("R7 high-active data", hi_ad_out, 8'h55);
        @(negedge clk); rd_n = 1'b1; @(negedge clk);
        do_write(1'b1, 8'h01, 1'b0, 8'h77);
        chk("R7 no strobe when deselected", strobes(), 6'b0);

        // R3: decode on bits 2:0 only
        do_write(1'b1, 8'hF9, 1'b1, 8'h5A);
        chk("R3 port A strobe", strobes(), 6'b010000);
        chk("R3 strobe data", wstb_data, 8'h5A);
        @(negedge clk);
        chk("R3 strobe one cycle", strobes(), 6'b0);
        do_write(1'b1, 8'h0A, 1'b1, 8'h12);
        chk("R3 port B strobe", strobes(), 6'b001000);
        do_write(1'b1, 8'h0B, 1'b1, 8'h13);
        chk("R3 port C strobe", strobes(), 6'b000100);
        do_write(1'b1, 8'h0C, 1'b1, 8'h21);
        chk("R3 count low strobe", strobes(), 6'b000010);
        do_write(1'b1, 8'h35, 1'b1, 8'h43);
        chk("R3 count high strobe", strobes(), 6'b000001);
        chk("R3 count high data", wstb_data, 8'h43);
        do_read(1'b1, 8'hF9, 1'b1, d, oe); chk("R3 read port A", d, 8'h96);
        do_read(1'b1, 8'hFA, 1'b1, d, oe); chk("R3 read port B", d, 8'hC4);
        do_read(1'b1, 8'h03, 1'b1, d, oe); chk("R3 read port C", d, 8'h2B);
        do_read(1'b1, 8'h04, 1'b1, d, oe); chk("R3 read count low", d, 8'h5E);
        do_read(1'b1, 8'hAD, 1'b1, d, oe); chk("R3 read count high", d, 8'h81);

        // R9: unused codes and bus enable
        do_write(1'b1, 8'h06, 1'b1, 8'hFF);
        chk("R9 unused write no strobe", strobes(), 6'b0);
        chk("R9 unused write cmd unchanged", cmd_now(), 8'h00);
        do_read(1'b1, 8'h07, 1'b1, d, oe);
        chk("R9 unused read value", d, 8'h00);
        chk("R9 unused read oe", oe, 1'b1);
        #1;
        chk("R9 oe low after read", ad_oe, 1'b0);

        // R4: command fields, never read back
        do_write(1'b1, 8'h00, 1'b1, 8'hE5);
        chk("R4 command strobe", strobes(), 6'b100000);
        chk("R4 pa dir", pa_is_out, 1'b1);
        chk("R4 pb dir", pb_is_out, 1'b0);
        chk("R4 pc mode", pc_mode, 2'b01);
        chk("R4 ie a/b", {irq_en_b, irq_en_a}, 2'b10);
        chk("R4 timer cmd", tmr_cmd, 2'b11);
        do_read(1'b1, 8'hF8, 1'b1, d, oe);
        chk("R4 read gives status", d, 8'h31);

        // R5: status layout with other inputs
        do_write(1'b1, 8'h00, 1'b1, 8'h1A);
        a_irq = 1'b0; a_full = 1'b1; b_irq = 1'b1; b_full = 1'b0;
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R5 status layout", d, exp_stat(8'h1A, 1'b0));

        // R6: timer flag
        pulse_tc();
        do_read(1'b1, 8'h01, 1'b1, d, oe);
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R6 flag shown and kept by other read", d, exp_stat(8'h1A, 1'b1));
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R6 flag cleared by status read", d, exp_stat(8'h1A, 1'b0));
        pulse_tc();
        addr_phase(1'b1, 8'h00, 1'b1);
        rd_n = 1'b0; #1;
        chk("R6 flag before collision", ad_out, exp_stat(8'h1A, 1'b1));
        @(negedge clk); rd_n = 1'b1; tmr_tc = 1'b1;
        @(negedge clk); tmr_tc = 1'b0;
        @(negedge clk);
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R6 set wins over clear", d, exp_stat(8'h1A, 1'b1));
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R6 cleared after", d, exp_stat(8'h1A, 1'b0));

        // R8: reset in mid-run
        do_write(1'b1, 8'h00, 1'b1, 8'hFF);
        pulse_tc();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; #1;
        chk("R8 cmd cleared", cmd_now(), 8'h00);
        do_read(1'b1, 8'h00, 1'b1, d, oe);
        chk("R8 flag and enables cleared", d, exp_stat(8'h00, 1'b0));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule